// File: doc/BRIEF.md
# Code-Density Bin Calibrator

This block calibrates a delay-chain time-to-digital converter whose raw bins are not all the same width; some are several times wider than the typical bin. Hits that arrive at random phase relative to the clock land in each raw bin in proportion to that bin's width. The block counts how often each raw code occurs, then turns the counts into a lookup table. Each table entry gives the time, in picoseconds, of the centre of its bin within one clock period.

After reset the table holds an ideal, evenly spaced mapping, and the block works as a translator: every valid raw code comes out one cycle later as a calibrated time. A start command, together with a hit target, clears the histogram and starts the learning phase. Raw codes are then counted until the target number of hits has been taken. The block then walks the bins one by one. For each bin it runs a sequential division that computes the running-sum position of the bin centre, and it writes the result into the table. When the last bin is written, translation resumes with the new table and a done flag is raised.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: After reset, busy and cal_done are low, time_valid is low, and the table holds the ideal mapping: code k translates to floor((2k+1)·PERIOD_PS / (2·2^CODE_W)).
- R2: When not busy, a raw code presented with raw_valid produces time_valid high one cycle later, with time_ps equal to the table entry for that code.
- R3: A cal_start while not busy clears the histogram, clears cal_done and raises busy the next cycle. A raw code presented in the same cycle is still translated with the old table and is not counted.
- R4: While busy, time_valid stays low. Raw codes that arrive during table generation are dropped and do not reach the histogram.
- R5: Learning ends with the accepted hit that brings the hit count to cal_target. A target of 0 behaves like a target of 1.
- R6: Each histogram counter saturates at 2^CNT_W−1. Hits to a saturated bin still count toward the target but do not add to the stored total S.
- R7: After generation, entry k equals floor((2·A_k + c_k)·PERIOD_PS / (2·S)), where c_k is the stored count of bin k, A_k is the sum of stored counts of bins below k, and S is the sum of all stored counts. Truncation is the default rounding.
- R8: When generation finishes, busy falls and cal_done rises. cal_done holds until the next accepted cal_start. A cal_start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Begin a calibration; accepted only when not busy |
| cal_target | input | TOT_W | Number of hits to collect, sampled with cal_start |
| raw_valid | input | 1 | Raw code strobe |
| raw_code | input | CODE_W | Raw delay-chain bin number |
| time_valid | output | 1 | Calibrated time strobe |
| time_ps | output | TIME_W | Calibrated time in picoseconds |
| busy | output | 1 | High while learning or building the table |
| cal_done | output | 1 | A calibration has finished and the table is in use |

## Verification
Two functions can fall in the same cycle. The first pair is a translation and the acceptance of a new calibration. The bench raises cal_start together with raw_valid and expects the code to come out with the old ideal value, while busy rises and cal_done clears. The histogram effect is judged later: the final table must match counts that leave that code out. The second pair is generation and incoming traffic. Codes for the last bin and a fresh cal_start are driven during generation, and the finished table must still equal the value computed from the learning-phase counts alone.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_LEARN = 2'd1,
      ST_BUILD = 2'd2
   } cal_state_e;
endpackage

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
   parameter int CODE_W = 7,
   parameter int CNT_W  = 16,
   parameter int SUM_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic [CODE_W-1:0] inc_code_i,
   input  logic [CODE_W-1:0] rd_idx_i,
   output logic [CNT_W-1:0]  rd_cnt_o,
   output logic [SUM_W-1:0]  sum_o
);
   localparam int NBINS = 1 << CODE_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q [NBINS];
   logic [SUM_W-1:0] sum_q;
   logic             room;

   assign room     = (cnt_q[inc_code_i] != CNT_MAX);
   assign rd_cnt_o = cnt_q[rd_idx_i];
   assign sum_o    = sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBINS; i++) cnt_q[i] <= '0;
         sum_q <= '0;
      end else if (clr_i) begin
         for (int i = 0; i < NBINS; i++) cnt_q[i] <= '0;
         sum_q <= '0;
      end else if (inc_i && room) begin
         cnt_q[inc_code_i] <= cnt_q[inc_code_i] + 1'b1;
         sum_q             <= sum_q + 1'b1;
      end
   end

   // R6: a full counter never wraps back
   for (genvar g = 0; g < NBINS; g++) begin : g_bin_chk
      a_r6_saturate : assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[g] == CNT_MAX && !clr_i) |=> (cnt_q[g] == CNT_MAX));
   end

   // R6: stored total grows by at most one per cycle
   a_r6_sum_step : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (sum_q == $past(sum_q) || sum_q == $past(sum_q) + 1'b1));
endmodule

// File: rtl/tdc_cal_div.sv
module tdc_cal_div #(
   parameter int NUM_W = 33,
   parameter int DEN_W = 21,
   parameter int Q_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [Q_W-1:0]   quo_o
);
   localparam int SW = $clog2(Q_W + 1);

   logic [DEN_W-1:0] den_q, rem_q;
   logic [Q_W-1:0]   lo_q, quo_q;
   logic [SW-1:0]    step_q;
   logic             act_q, done_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial  = {rem_q, lo_q[Q_W-1]};
   assign fits   = (trial >= {1'b0, den_q});
   assign done_o = done_q;
   assign quo_o  = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         den_q  <= '0;
         rem_q  <= '0;
         lo_q   <= '0;
         quo_q  <= '0;
         step_q <= '0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            den_q  <= den_i;
            rem_q  <= DEN_W'(num_i >> Q_W);
            lo_q   <= num_i[Q_W-1:0];
            quo_q  <= '0;
            step_q <= SW'(Q_W);
            act_q  <= 1'b1;
         end else if (act_q) begin
            rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
            lo_q   <= lo_q << 1;
            quo_q  <= {quo_q[Q_W-2:0], fits};
            step_q <= step_q - 1'b1;
            if (step_q == SW'(1)) begin
               act_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R7: partial remainder stays below the divisor
   a_r7_rem_below_den : assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (rem_q < den_q));
   // R7: no new division launched over a running one
   a_r7_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !act_q);
endmodule

// File: rtl/tdc_cal_lut.sv
module tdc_cal_lut #(
   parameter int CODE_W    = 7,
   parameter int TIME_W    = 12,
   parameter int PERIOD_PS = 2500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CODE_W-1:0] wr_idx_i,
   input  logic [TIME_W-1:0] wr_time_i,
   input  logic              rd_i,
   input  logic [CODE_W-1:0] rd_idx_i,
   output logic              rd_valid_o,
   output logic [TIME_W-1:0] rd_time_o
);
   localparam int NBINS = 1 << CODE_W;

   function automatic logic [TIME_W-1:0] ideal_time(int unsigned k);
      longint unsigned t;
      t = (64'(2 * k + 1) * 64'(PERIOD_PS)) / 64'(2 * NBINS);
      return TIME_W'(t);
   endfunction

   logic [TIME_W-1:0] tab_q [NBINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBINS; i++) tab_q[i] <= ideal_time(i);
      end else if (wr_i) begin
         tab_q[wr_idx_i] <= wr_time_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_time_o  <= '0;
      end else begin
         rd_valid_o <= rd_i;
         if (rd_i) rd_time_o <= tab_q[rd_idx_i];
      end
   end

   // R2: every output strobe answers a read one cycle earlier
   a_r2_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(rd_i));
   // R4: reads and writes never overlap
   a_r4_no_rw_mix : assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> !rd_i);
endmodule

// File: rtl/tdc_bin_calibrator.sv
module tdc_bin_calibrator
   import tdc_cal_pkg::*;
#(
   parameter int CODE_W        = 7,
   parameter int CNT_W         = 16,
   parameter int TOT_W         = 20,
   parameter int TIME_W        = 12,
   parameter int PERIOD_PS     = 2500,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic [TOT_W-1:0]  cal_target,
   input  logic              raw_valid,
   input  logic [CODE_W-1:0] raw_code,
   output logic              time_valid,
   output logic [TIME_W-1:0] time_ps,
   output logic              busy,
   output logic              cal_done
);
   localparam int NBINS = 1 << CODE_W;
   localparam int SUM_W = TOT_W;
   localparam int TW    = SUM_W + 1;
   localparam int DEN_W = SUM_W + 1;
   localparam int NUM_W = SUM_W + 1 + TIME_W;
   localparam int HW    = TOT_W + 1;
   localparam logic [CODE_W-1:0] LAST_BIN = CODE_W'(NBINS - 1);

   if (CODE_W < 1) begin : g_chk_code
      $error("CODE_W must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > SUM_W) begin : g_chk_cnt
      $error("CNT_W must lie in 1..TOT_W");
   end
   if (TIME_W < 2) begin : g_chk_time
      $error("TIME_W must be at least 2");
   end
   if (PERIOD_PS < 1 || PERIOD_PS + 1 >= (1 << TIME_W)) begin : g_chk_period
      $error("PERIOD_PS must be positive and fit TIME_W with headroom");
   end

   cal_state_e         st_q;
   logic [TOT_W-1:0]   tgt_q, hits_q;
   logic [CODE_W-1:0]  bin_q;
   logic [SUM_W-1:0]   acc_q;
   logic               wait_q, done_q;

   logic               in_run, in_learn, in_build;
   logic               start_go, hit_take, last_hit;
   logic [CNT_W-1:0]   cnt_k;
   logic [SUM_W-1:0]   sum_all;
   logic [TW-1:0]      twice;
   logic [NUM_W-1:0]   prod, num;
   logic               div_start, div_done;
   logic [TIME_W-1:0]  quo;

   assign in_run   = (st_q == ST_RUN);
   assign in_learn = (st_q == ST_LEARN);
   assign in_build = (st_q == ST_BUILD);
   assign start_go = in_run && cal_start;
   assign hit_take = in_learn && raw_valid;
   assign last_hit = hit_take && ((HW'(hits_q) + HW'(1)) >= HW'(tgt_q));

   tdc_cal_hist #(
      .CODE_W (CODE_W),
      .CNT_W  (CNT_W),
      .SUM_W  (SUM_W)
   ) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start_go),
      .inc_i      (hit_take),
      .inc_code_i (raw_code),
      .rd_idx_i   (bin_q),
      .rd_cnt_o   (cnt_k),
      .sum_o      (sum_all)
   );

   // bin centre in units of half a count: 2*A_k + c_k
   assign twice = {acc_q, 1'b0} + TW'(cnt_k);
   assign prod  = NUM_W'(twice) * NUM_W'(PERIOD_PS);

   if (ROUND_NEAREST) begin : g_round
      assign num = prod + NUM_W'(sum_all);
   end else begin : g_trunc
      assign num = prod;
   end

   assign div_start = in_build && !wait_q;

   tdc_cal_div #(
      .NUM_W (NUM_W),
      .DEN_W (DEN_W),
      .Q_W   (TIME_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (num),
      .den_i   ({sum_all, 1'b0}),
      .done_o  (div_done),
      .quo_o   (quo)
   );

   tdc_cal_lut #(
      .CODE_W    (CODE_W),
      .TIME_W    (TIME_W),
      .PERIOD_PS (PERIOD_PS)
   ) u_lut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (div_done),
      .wr_idx_i   (bin_q),
      .wr_time_i  (quo),
      .rd_i       (in_run && raw_valid),
      .rd_idx_i   (raw_code),
      .rd_valid_o (time_valid),
      .rd_time_o  (time_ps)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         tgt_q  <= '0;
         hits_q <= '0;
         bin_q  <= '0;
         acc_q  <= '0;
         wait_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (cal_start) begin
                  st_q   <= ST_LEARN;
                  tgt_q  <= cal_target;
                  hits_q <= '0;
                  done_q <= 1'b0;
               end
            end
            ST_LEARN: begin
               if (hit_take) hits_q <= hits_q + 1'b1;
               if (last_hit) begin
                  st_q   <= ST_BUILD;
                  bin_q  <= '0;
                  acc_q  <= '0;
                  wait_q <= 1'b0;
               end
            end
            ST_BUILD: begin
               if (div_start) wait_q <= 1'b1;
               if (div_done) begin
                  wait_q <= 1'b0;
                  acc_q  <= acc_q + SUM_W'(cnt_k);
                  bin_q  <= bin_q + 1'b1;
                  if (bin_q == LAST_BIN) begin
                     st_q   <= ST_RUN;
                     done_q <= 1'b1;
                  end
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign busy     = !in_run;
   assign cal_done = done_q;

   // R4: no calibrated output follows a busy cycle
   a_r4_busy_mute : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !time_valid);
   // R3: an accepted start enters learning with the flag cleared
   a_r3_start_enters : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cal_start) |=> (busy && !cal_done));
   // R8: done flag persists until a new start
   a_r8_done_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !cal_start) |=> cal_done);
   // R8: done and busy never overlap
   a_r8_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> !busy);
   // R5: the hit count never runs past the target while learning
   a_r5_hits_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      (in_learn && tgt_q != '0) |-> (hits_q < tgt_q));
endmodule

// File: tb/tdc_bin_calibrator_test.sv
module tdc_bin_calibrator_test;
   localparam int CW  = 3;
   localparam int NB  = 1 << CW;
   localparam int KW  = 4;
   localparam int TW  = 8;
   localparam int QW  = 12;
   localparam int PER = 2500;
   localparam int CMAX = (1 << KW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cal_start = 1'b0;
   logic [TW-1:0] cal_target = '0;
   logic          raw_valid = 1'b0;
   logic [CW-1:0] raw_code = '0;
   logic          time_valid;
   logic [QW-1:0] time_ps;
   logic          busy;
   logic          cal_done;

   int n_chk = 0;
   int n_bad = 0;
   int exp_cnt [NB];
   int exp_tab [NB];

   always #2 clk = ~clk;

   tdc_bin_calibrator #(
      .CODE_W    (CW),
      .CNT_W     (KW),
      .TOT_W     (TW),
      .TIME_W    (QW),
      .PERIOD_PS (PER)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_start  (cal_start),
      .cal_target (cal_target),
      .raw_valid  (raw_valid),
      .raw_code   (raw_code),
      .time_valid (time_valid),
      .time_ps    (time_ps),
      .busy       (busy),
      .cal_done   (cal_done)
   );

   function automatic int ideal(int k);
      return ((2 * k + 1) * PER) / (2 * NB);
   endfunction

   function automatic void model_table();
      longint s, a;
      s = 0;
      a = 0;
      for (int k = 0; k < NB; k++) s += exp_cnt[k];
      for (int k = 0; k < NB; k++) begin
         exp_tab[k] = int'(((2 * a + exp_cnt[k]) * PER) / (2 * s));
         a += exp_cnt[k];
      end
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic translate(int code, int expv, string req);
      @(negedge clk);
      raw_valid = 1'b1;
      raw_code  = CW'(code);
      @(negedge clk);
      raw_valid = 1'b0;
      check(time_valid === 1'b1, req, "time_valid", int'(time_valid), 1);
      check(int'(time_ps) == expv, req, $sformatf("time of code %0d", code),
            int'(time_ps), expv);
   endtask

   task automatic hit(int code);
      @(negedge clk);
      raw_valid = 1'b1;
      raw_code  = CW'(code);
      @(negedge clk);
      raw_valid = 1'b0;
      if (exp_cnt[code] < CMAX) exp_cnt[code]++;
      check(time_valid === 1'b0, "R4", "time_valid while learning", int'(time_valid), 0);
   endtask

   task automatic begin_cal(int target);
      @(negedge clk);
      cal_start  = 1'b1;
      cal_target = TW'(target);
      @(negedge clk);
      cal_start  = 1'b0;
      for (int k = 0; k < NB; k++) exp_cnt[k] = 0;
      check(busy === 1'b1, "R3", "busy after start", int'(busy), 1);
      check(cal_done === 1'b0, "R3", "cal_done after start", int'(cal_done), 0);
   endtask

   task automatic wait_done(string req);
      int n;
      n = 0;
      while (cal_done !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(cal_done === 1'b1, req, "cal_done raised", int'(cal_done), 1);
      check(busy === 1'b0, req, "busy after build", int'(busy), 0);
   endtask

   task automatic sweep(string req);
      model_table();
      for (int k = 0; k < NB; k++) translate(k, exp_tab[k], req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(cal_done === 1'b0, "R1", "cal_done in reset", int'(cal_done), 0);
      check(time_valid === 1'b0, "R1", "time_valid in reset", int'(time_valid), 0);
      rst_n = 1'b1;
      for (int k = 0; k < NB; k++) translate(k, ideal(k), "R1");
      translate(3, ideal(3), "R2");
      @(negedge clk);
      check(time_valid === 1'b0, "R2", "strobe drops without input", int'(time_valid), 0);

      // R3: start and translation in the same cycle
      @(negedge clk);
      cal_start  = 1'b1;
      cal_target = TW'(20);
      raw_valid  = 1'b1;
      raw_code   = CW'(5);
      @(negedge clk);
      cal_start = 1'b0;
      raw_valid = 1'b0;
      for (int k = 0; k < NB; k++) exp_cnt[k] = 0;
      check(time_valid === 1'b1, "R3", "overlapping code translated", int'(time_valid), 1);
      check(int'(time_ps) == ideal(5), "R3", "old table used", int'(time_ps), ideal(5));
      check(busy === 1'b1, "R3", "busy after start", int'(busy), 1);
      check(cal_done === 1'b0, "R3", "cal_done after start", int'(cal_done), 0);

      // uneven widths, one empty and one wide bin: counts 1,2,3,4,0,6,2,2
      for (int r = 0; r < 6; r++) begin
         if (r < 1) hit(0);
         if (r < 2) hit(1);
         if (r < 3) hit(2);
         if (r < 4) hit(3);
         hit(5);
         if (r == 2) begin
            // R8: start while busy is ignored
            @(negedge clk);
            cal_start  = 1'b1;
            cal_target = TW'(3);
            @(negedge clk);
            cal_start = 1'b0;
         end
         if (r < 2) begin
            hit(6);
            hit(7);
         end
      end
      check(busy === 1'b1, "R5", "building after target", int'(busy), 1);
      // R4: codes during build are dropped
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         raw_valid = 1'b1;
         raw_code  = CW'(7);
         @(negedge clk);
         raw_valid = 1'b0;
         check(time_valid === 1'b0, "R4", "time_valid during build", int'(time_valid), 0);
      end
      wait_done("R8");
      sweep("R7");

      // R6: saturation, 25 hits on bin 2 and 15 on bin 6
      begin_cal(40);
      for (int i = 0; i < 25; i++) hit(2);
      for (int i = 0; i < 14; i++) hit(6);
      check(busy === 1'b1, "R5", "still learning one hit short", int'(busy), 1);
      hit(6);
      @(negedge clk);
      cal_start  = 1'b1;
      cal_target = TW'(1);
      @(negedge clk);
      cal_start = 1'b0;
      wait_done("R8");
      repeat (3) @(negedge clk);
      check(cal_done === 1'b1, "R8", "cal_done holds", int'(cal_done), 1);
      check(busy === 1'b0, "R8", "stays idle", int'(busy), 0);
      sweep("R6");

      // R5: target 0 acts as 1
      begin_cal(0);
      hit(3);
      wait_done("R5");
      check(exp_cnt[3] == 1, "R5", "single hit model", exp_cnt[3], 1);
      sweep("R5");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule